// File: doc/BRIEF.md
# Digital Input Glitch Qualifier

The block cleans up a bank of asynchronous input pins before the rest of the chip uses them. Each raw pin is brought into the system clock domain by a two-flop synchronizer. A prescaler shared by the whole bank produces a sampling tick. It fires on every clock when the period setting is zero, and once every 2n clocks for a nonzero setting n. At each tick every pin records its synchronized level in its own history.

Each pin chooses how strictly it is qualified. In six-sample mode the qualified level moves only when six consecutive ticks agree. In three-sample mode three agreeing ticks are enough. Two further modes bypass filtering. One forwards the synchronized level. The other forwards the raw pin with no register at all. A burst that is shorter than the window set by the mode leaves the qualified output at its previous level.

When the period setting changes, the prescaler finishes its current interval first. The new interval is taken only at the next tick.

Top module: `pin_glitch_filter`

## Requirements
- R1: Reset (rst_n low, asynchronous) forces every registered qualified output and every sample history to 0 and restarts the prescaler count from zero.
- R2: With period = 0 a sampling tick occurs on every clock. With period = n > 0 ticks occur exactly every 2n clocks.
- R3: Mode code 2'b10 (six-sample) on bits [2i+1:2i] of `mode` changes pin i's output only at a tick where the six most recent samples are all 1 (output becomes 1) or all 0 (output becomes 0). A high burst lasting at least 6 tick periods is always accepted. One lasting at most 5 tick periods is always rejected.
- R4: Mode code 2'b01 (three-sample) behaves the same way with three samples. A burst of at least 3 tick periods is always accepted, and one of at most 2 tick periods is always rejected.
- R5: Mode code 2'b00 forwards the synchronized pin with no filtering. An input change made before clock edge 1 appears on the output after edge 3.
- R6: Mode code 2'b11 routes the raw pin combinationally to the output, with no clock edge needed.
- R7: With period = 0, an input change made before clock edge 1 appears after edge 8 in six-sample mode and after edge 5 in three-sample mode. Before those edges the old level is held.
- R8: All eight pins share one tick, and each pin is qualified by its own mode, independently of the others.
- R9: With period = 1 in six-sample mode, a 13-clock pulse is recognized at every phase of the tick, and a 9-clock pulse never is.
- R10: A new period value takes effect only at the next tick. Until then the interval loaded earlier stays in force.
- R11: The largest period, 0xFF (a tick every 510 clocks), qualifies correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 8 | Raw asynchronous pin levels |
| period | input | 8 | Tick period setting n (0 = every clock, else 2n clocks) |
| mode | input | 16 | Two bits per pin selecting the qualification mode |
| pin_qual | output | 8 | Qualified pin levels |

## Verification
With period zero, the bench raises pins before clock edge 1 and checks the output after every edge. It expects the change at edge 3 for pass-through, edge 5 for three-sample mode and edge 8 for six-sample mode, and the old level at every earlier edge. For nonzero periods the tick phase is not visible at the ports. Pulse lengths are therefore chosen so that the result does not depend on phase: at least N tick periods must be accepted and at most N-1 must be rejected. Each pulse is repeated at every phase offset, by making each trial one clock longer than a multiple of the period. After each pulse the bench waits more than eight tick periods with the pin low, and only then checks that the output has returned to zero. The reload test fires a pulse in the first 510 clocks after reset, while the period loaded at reset still holds.

// File: rtl/pgf_pkg.sv
package pgf_pkg;
    typedef enum logic [1:0] {
        QM_SYNC  = 2'b00,
        QM_THREE = 2'b01,
        QM_SIX   = 2'b10,
        QM_RAW   = 2'b11
    } qual_mode_e;

    localparam int LONG_WIN  = 6;
    localparam int SHORT_WIN = 3;
endpackage

// File: rtl/pgf_sample_tick.sv
module pgf_sample_tick #(
    parameter int PRD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRD_W-1:0] period_i,
    output logic             tick_o
);
    localparam int CNT_W = PRD_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
    } tick_st_t;

    tick_st_t st_q, st_d;
    logic [CNT_W-1:0] lim_new;

    always_comb begin
        lim_new = (period_i == '0) ? '0 : ({period_i, 1'b0} - CNT_W'(1));
        tick_o  = (st_q.cnt >= st_q.lim);
        st_d    = st_q;
        if (tick_o) begin
            st_d.cnt = '0;
            st_d.lim = lim_new;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: the count never runs past the loaded interval
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.lim);

    // R10: the loaded interval only changes across a tick
    a_r10_limit_held: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_o |=> $stable(st_q.lim));
endmodule

// File: rtl/pgf_sync2.sv
module pgf_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic meta;
        logic stable;
    } sync_st_t;

    sync_st_t st_q, st_d;

    always_comb begin
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
        sync_o      = st_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pgf_qual_lane.sv
module pgf_qual_lane
    import pgf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw_i,
    input  logic       synced_i,
    input  logic       tick_i,
    input  qual_mode_e mode_i,
    output logic       level_o
);
    localparam int HW = LONG_WIN - 1;

    typedef struct packed {
        logic [HW-1:0] hist;
        logic          lvl;
    } lane_st_t;

    lane_st_t st_q, st_d;
    logic [LONG_WIN-1:0] window;
    logic long_hi, long_lo, short_hi, short_lo;

    always_comb begin
        window   = {st_q.hist, synced_i};
        long_hi  = &window;
        long_lo  = ~|window;
        short_hi = &window[SHORT_WIN-1:0];
        short_lo = ~|window[SHORT_WIN-1:0];
        st_d     = st_q;
        if (tick_i) st_d.hist = window[HW-1:0];
        case (mode_i)
            QM_SIX: begin
                if (tick_i && long_hi)      st_d.lvl = 1'b1;
                else if (tick_i && long_lo) st_d.lvl = 1'b0;
            end
            QM_THREE: begin
                if (tick_i && short_hi)      st_d.lvl = 1'b1;
                else if (tick_i && short_lo) st_d.lvl = 1'b0;
            end
            default: st_d.lvl = synced_i;
        endcase
        level_o = (mode_i == QM_RAW) ? raw_i : st_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: between ticks a six-sample lane holds its level
    a_r3_six_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == QM_SIX && !tick_i) |=> $stable(st_q.lvl));

    // R3: a tick that completes six high samples leaves the lane high
    a_r3_six_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == QM_SIX && tick_i && synced_i && (&st_q.hist)) |=> st_q.lvl);

    // R4: between ticks a three-sample lane holds its level
    a_r4_three_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == QM_THREE && !tick_i) |=> $stable(st_q.lvl));

    // R5: pass-through lane follows the synchronizer one clock later
    a_r5_sync_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == QM_SYNC) |=> (st_q.lvl == $past(synced_i)));
endmodule

// File: rtl/pin_glitch_filter.sv
module pin_glitch_filter
    import pgf_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int PRD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPINS-1:0]   pin_raw,
    input  logic [PRD_W-1:0]   period,
    input  logic [2*NPINS-1:0] mode,
    output logic [NPINS-1:0]   pin_qual
);
    logic tick;
    logic [NPINS-1:0] synced;

    pgf_sample_tick #(.PRD_W(PRD_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (period),
        .tick_o   (tick)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pgf_sync2 u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (pin_raw[i]),
            .sync_o  (synced[i])
        );

        pgf_qual_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_i    (pin_raw[i]),
            .synced_i (synced[i]),
            .tick_i   (tick),
            .mode_i   (qual_mode_e'(mode[2*i +: 2])),
            .level_o  (pin_qual[i])
        );
    end
endmodule

// File: tb/pin_glitch_filter_test.sv
module pin_glitch_filter_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_raw = '0;
    logic [7:0]  period = 8'hFF;
    logic [15:0] mode;
    logic [7:0]  pin_qual;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // pins 0-2 six, 3-5 three, 6 pass-through, 7 six
    localparam logic [15:0] STD_MODE = 16'b10_00_01_01_01_10_10_10;

    pin_glitch_filter uut (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw),
        .period(period), .mode(mode), .pin_qual(pin_qual)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic int win_len(input logic [1:0] m);
        case (m)
            2'b10:   return 6;
            2'b01:   return 3;
            default: return 1;
        endcase
    endfunction

    task automatic set_period(input logic [7:0] n);
        period = n;
        repeat (600) @(negedge clk);
    endtask

    // w-clock pulse on all pins, repeated reps times at shifting phases
    task automatic pulse_sweep(input int w, input int n, input int reps, input string req);
        int p = (n == 0) ? 1 : 2 * n;
        for (int r = 0; r < reps; r++) begin
            logic [7:0] seen;
            int post;
            int pad;
            seen = '0;
            post = 8 * p + 8;
            pad  = ((1 - ((w + post) % p)) % p + p) % p;
            pin_raw = 8'hFF;
            repeat (w) begin
                @(negedge clk);
                seen |= pin_qual;
            end
            pin_raw = 8'h00;
            repeat (post + pad) begin
                @(negedge clk);
                seen |= pin_qual;
            end
            for (int i = 0; i < 8; i++) begin
                int nn = win_len(mode[2*i +: 2]);
                int pe = (nn == 1) ? 1 : p;
                if (w >= nn * pe)
                    check(req, {7'b0, seen[i]}, 8'd1);
                else if (w <= (nn - 1) * pe)
                    check(req, {7'b0, seen[i]}, 8'd0);
            end
            check({req, " R3 R4 return low"}, pin_qual, 8'h00);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        mode = STD_MODE;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", pin_qual, 8'h00);
        rst_n = 1'b1;

        // R10: period 0xFF loaded at first tick; change to 0 is deferred
        repeat (10) @(negedge clk);
        period = 8'h00;
        pulse_sweep(6, 255, 1, "R10 deferred reload");
        repeat (600) @(negedge clk);
        pulse_sweep(6, 0, 1, "R10 new period active");

        // R7 / R5 latency with period 0
        mode = 16'b10_10_10_10_10_00_01_10;
        repeat (20) @(negedge clk);
        pin_raw = 8'h07;
        for (int j = 1; j <= 10; j++) begin
            @(negedge clk);
            check("R7 six rise latency", {7'b0, pin_qual[0]}, {7'b0, j >= 8});
            check("R7 three rise latency", {7'b0, pin_qual[1]}, {7'b0, j >= 5});
            check("R5 sync rise latency", {7'b0, pin_qual[2]}, {7'b0, j >= 3});
        end
        pin_raw = 8'h00;
        for (int j = 1; j <= 10; j++) begin
            @(negedge clk);
            check("R7 six fall latency", {7'b0, pin_qual[0]}, {7'b0, j < 8});
            check("R7 three fall latency", {7'b0, pin_qual[1]}, {7'b0, j < 5});
            check("R5 sync fall latency", {7'b0, pin_qual[2]}, {7'b0, j < 3});
        end

        // R6 raw pass-through, mid-cycle
        mode = 16'b10_10_10_10_11_10_10_10;
        repeat (2) @(negedge clk);
        #1 pin_raw = 8'h08;
        #1 check("R6 raw high", pin_qual & 8'h08, 8'h08);
        #1 pin_raw = 8'h00;
        #1 check("R6 raw low", pin_qual & 8'h08, 8'h00);

        // R2 R3 R4 R8 sweeps over small periods at every phase
        mode = STD_MODE;
        for (int n = 0; n <= 3; n++) begin
            int p = (n == 0) ? 1 : 2 * n;
            set_period(8'(n));
            pulse_sweep(2 * p, n, p, "R2 R4 R8 two periods");
            pulse_sweep(3 * p, n, p, "R2 R4 R8 three periods");
            pulse_sweep(5 * p, n, p, "R2 R3 R8 five periods");
            pulse_sweep(6 * p, n, p, "R2 R3 R8 six periods");
        end

        // R9 period 1, six-sample
        set_period(8'd1);
        pulse_sweep(13, 1, 4, "R9 13-clock pulse");
        pulse_sweep(9, 1, 4, "R9 9-clock pulse");

        // R11 maximum period
        set_period(8'hFF);
        pulse_sweep(2 * 510, 255, 1, "R11 max period two");
        pulse_sweep(3 * 510, 255, 1, "R11 max period three");
        pulse_sweep(6 * 510, 255, 1, "R11 max period six");

        // R1 reset while outputs are high
        set_period(8'h00);
        pin_raw = 8'hFF;
        repeat (20) @(negedge clk);
        check("R1 outputs high before reset", pin_qual, 8'hFF);
        pin_raw = 8'h00;
        rst_n = 1'b0;
        #1 check("R1 reset clears outputs", pin_qual, 8'h00);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 outputs low after reset", pin_qual, 8'h00);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule